// File: doc/BRIEF.md
# Link-Up Monitor with Speed-Change Recovery

This block decides, after link training has been switched on, whether a serial link has come up. A stuck speed upgrade is handled by briefly forcing two PHY receiver controls. On every check it looks at two debug status words from the link controller. If those words show an active link outside of training, it reports the link as up. Otherwise it reads a receiver status register in the PHY through a simple request/acknowledge port. When the receiver is not valid and the training state machine sits in receiver-lock recovery, it runs a recovery sequence:

- read the receiver override register;
- set its data-enable and PLL-enable bits and write the value back;
- wait a programmable hold time;
- read the register again, clear the two bits and write it back.

Checks repeat at a fixed interval until the link is up or an attempt budget runs out. A start pulse arms the monitor. The verdicts `link_up` and `link_fail` stay set until the next start. `stuck_evt` pulses for one cycle each time a recovery begins. All delays are parameters counted in clock cycles, so a simulation can use short values.

Top module: `lum_link_monitor`

## Requirements
- R1: After reset, `link_up`, `link_fail`, `stuck_evt` and `phy_req` are all 0 and the monitor is idle.
- R2: The link counts as up when `dbg_word1` bit 4 is 1 and bit 29 is 0. If this holds in the first check after `start`, `link_up` is 1 on the second rising edge after the edge that samples `start`. It then stays 1, with no PHY access, until the next `start`.
- R3: When the link is not up, the check issues a PHY read (`phy_we`=0) of address 0x100D, and `link_up` stays 0.
- R4: If bit 0 of the data read from 0x100D is 1, the attempt ends without any access to address 0x1005 and without a `stuck_evt` pulse.
- R5: If bit 0 of the 0x100D data is 0 and `dbg_word0[5:0]` equals 0x0D, the block pulses `stuck_evt` for exactly one cycle. It then reads 0x1005 and writes back the read value OR 0x0028, that is, bits 5 and 3 set.
- R6: At least RECOV_CYC cycles after the acknowledge of that write, the block reads 0x1005 again. It then writes back the read value AND NOT 0x0028.
- R7: If bit 0 of the 0x100D data is 0 and `dbg_word0[5:0]` is not 0x0D, no access to 0x1005 takes place.
- R8: After MAX_TRIES unsuccessful checks, `link_fail` becomes 1. The run then holds exactly MAX_TRIES reads of 0x100D, and no further PHY request follows while `link_fail` is 1. `link_up` and `link_fail` are never 1 together.
- R9: Two consecutive reads of 0x100D start at least GAP_CYC cycles apart.
- R10: A PHY access that gets no acknowledge is dropped after exactly PHY_TMO cycles of `phy_req`. It counts as one failed attempt, and monitoring carries on until the attempt budget is used up.
- R11: `start` clears `link_up`, `link_fail` and the attempt count on the edge that samples it, and begins a new check sequence.
- R12: `phy_req` stays high with `phy_addr`, `phy_we` and `phy_wdata` stable until `phy_ack`. It falls in the cycle after the acknowledge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms the monitor and clears the verdicts and the attempt count |
| dbg_word0 | input | 32 | Link controller debug word 0; bits 5:0 hold the training state |
| dbg_word1 | input | 32 | Link controller debug word 1; bit 4 means link up, bit 29 means in training |
| phy_req | output | 1 | PHY access request, held until acknowledged or timed out |
| phy_we | output | 1 | 1 = write, 0 = read |
| phy_addr | output | 16 | PHY register address |
| phy_wdata | output | 16 | PHY write data |
| phy_ack | input | 1 | One-cycle acknowledge from the PHY access sequencer |
| phy_rdata | input | 16 | Read data, valid with `phy_ack` |
| link_up | output | 1 | Sticky: link detected up |
| link_fail | output | 1 | Sticky: attempt budget exhausted |
| stuck_evt | output | 1 | One-cycle pulse at the start of each recovery |

## Verification
Only two results have fixed latencies:

- `link_up` and the clearing of both verdicts: `link_up` rises on the second rising edge after the edge that samples `start`, and both verdicts clear on that first edge. The bench drives on falling edges and samples on the falling edge just after each of those edges.
- The request hold under timeout: it is exactly PHY_TMO cycles, and the bench compares it with that value.

Every other result depends on the latency of the PHY model, so the bench records PHY traffic on each rising edge and tests it against bounds:

- the number of 0x100D reads that precede `link_fail`;
- the smallest spacing between checks, against GAP_CYC;
- the smallest distance from the set-write acknowledge to the next 0x1005 read, against RECOV_CYC;
- the width of each `stuck_evt` pulse.

// File: rtl/lum_pkg.sv
package lum_pkg;

  localparam int DBG_W   = 32;
  localparam int PHY_AW  = 16;
  localparam int PHY_DW  = 16;
  localparam int LTSSM_W = 6;

  // debug word 1 bit positions
  localparam int UP_BIT    = 4;
  localparam int TRAIN_BIT = 29;

  // training state code of receiver-lock recovery
  localparam logic [LTSSM_W-1:0] LTSSM_RCV_LOCK = 6'h0D;

  // PHY register map used by the monitor
  localparam logic [PHY_AW-1:0] ADDR_RX_STAT = 16'h100D;
  localparam logic [PHY_AW-1:0] ADDR_RX_OVR  = 16'h1005;
  localparam int                RXV_BIT      = 0;
  localparam logic [PHY_DW-1:0] OVR_MASK     = 16'h0028;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RXV,
    ST_RD1,
    ST_WR1,
    ST_HOLD,
    ST_RD2,
    ST_WR2,
    ST_GAP,
    ST_UP,
    ST_FAIL
  } mon_st_e;

endpackage

// File: rtl/lum_status_decode.sv
module lum_status_decode
  import lum_pkg::*;
(
  input  logic [DBG_W-1:0] dbg_word0,
  input  logic [DBG_W-1:0] dbg_word1,
  output logic             link_ok,
  output logic             rcv_lock_state
);

  logic [LTSSM_W-1:0] ltssm;
  logic               unused_dbg;

  always_comb begin
    ltssm          = dbg_word0[LTSSM_W-1:0];
    link_ok        = dbg_word1[UP_BIT] & ~dbg_word1[TRAIN_BIT];
    rcv_lock_state = (ltssm == LTSSM_RCV_LOCK);
  end

  assign unused_dbg = ^{dbg_word0[DBG_W-1:LTSSM_W], dbg_word1[DBG_W-1:TRAIN_BIT+1],
                        dbg_word1[TRAIN_BIT-1:UP_BIT+1], dbg_word1[UP_BIT-1:0]};

endmodule

// File: rtl/lum_phy_port.sv
module lum_phy_port #(
  parameter int PHY_TMO = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic acc_en,
  input  logic abort,
  input  logic phy_ack,
  output logic phy_req,
  output logic acc_ok,
  output logic acc_tmo
);

  localparam int TW = $clog2(PHY_TMO + 1);

  logic          req_q, req_d;
  logic [TW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    acc_ok  = req_q & phy_ack;
    acc_tmo = req_q & ~phy_ack & (tcnt_q == TW'(PHY_TMO - 1));
    req_d   = acc_en & ~abort & ~acc_ok & ~acc_tmo;
    tcnt_d  = (req_q && !acc_ok && !acc_tmo) ? tcnt_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      tcnt_q <= '0;
    end else begin
      req_q  <= req_d;
      tcnt_q <= tcnt_d;
    end
  end

  assign phy_req = req_q;

endmodule

// File: rtl/lum_delay.sv
module lum_delay #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/lum_link_monitor.sv
module lum_link_monitor
  import lum_pkg::*;
#(
  parameter int GAP_CYC   = 500,
  parameter int RECOV_CYC = 150000,
  parameter int MAX_TRIES = 4000,
  parameter int PHY_TMO   = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DBG_W-1:0]  dbg_word0,
  input  logic [DBG_W-1:0]  dbg_word1,
  output logic              phy_req,
  output logic              phy_we,
  output logic [PHY_AW-1:0] phy_addr,
  output logic [PHY_DW-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [PHY_DW-1:0] phy_rdata,
  output logic              link_up,
  output logic              link_fail,
  output logic              stuck_evt
);

  localparam int DLY_MAX = (GAP_CYC > RECOV_CYC) ? GAP_CYC : RECOV_CYC;
  localparam int DW      = $clog2(DLY_MAX + 1);
  localparam int CW      = $clog2(MAX_TRIES + 1);

  mon_st_e           st_q, st_d;
  logic [CW-1:0]     tries_q, tries_d;
  logic [PHY_DW-1:0] ov_q, ov_d;
  logic              up_q, up_d, fail_q, fail_d, evt_q, evt_d;
  logic              ov_en;
  logic              link_ok, rcv_lock_state;
  logic              acc_en, acc_ok, acc_tmo, miss;
  logic              dly_load, dly_exp;
  logic [DW-1:0]     dly_val;

  lum_status_decode u_dec (
    .dbg_word0      (dbg_word0),
    .dbg_word1      (dbg_word1),
    .link_ok        (link_ok),
    .rcv_lock_state (rcv_lock_state)
  );

  lum_phy_port #(.PHY_TMO(PHY_TMO)) u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (acc_en),
    .abort   (start),
    .phy_ack (phy_ack),
    .phy_req (phy_req),
    .acc_ok  (acc_ok),
    .acc_tmo (acc_tmo)
  );

  lum_delay #(.W(DW)) u_dly (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (dly_load),
    .load_val (dly_val),
    .expired  (dly_exp)
  );

  // next-state logic
  always_comb begin
    st_d     = st_q;
    tries_d  = tries_q;
    up_d     = up_q;
    fail_d   = fail_q;
    evt_d    = 1'b0;
    ov_d     = ov_q;
    ov_en    = 1'b0;
    dly_load = 1'b0;
    dly_val  = '0;
    acc_en   = 1'b0;
    miss     = 1'b0;

    unique case (st_q)
      ST_CHECK: begin
        if (link_ok) begin
          st_d = ST_UP;
          up_d = 1'b1;
        end else begin
          st_d = ST_RXV;
        end
      end
      ST_RXV: begin
        acc_en = 1'b1;
        if (acc_tmo) begin
          miss = 1'b1;
        end else if (acc_ok) begin
          if (!phy_rdata[RXV_BIT] && rcv_lock_state) begin
            st_d  = ST_RD1;
            evt_d = 1'b1;
          end else begin
            miss = 1'b1;
          end
        end
      end
      ST_RD1, ST_RD2: begin
        acc_en = 1'b1;
        if (acc_tmo) begin
          miss = 1'b1;
        end else if (acc_ok) begin
          ov_en = 1'b1;
          ov_d  = phy_rdata;
          st_d  = (st_q == ST_RD1) ? ST_WR1 : ST_WR2;
        end
      end
      ST_WR1: begin
        acc_en = 1'b1;
        if (acc_tmo) begin
          miss = 1'b1;
        end else if (acc_ok) begin
          st_d     = ST_HOLD;
          dly_load = 1'b1;
          dly_val  = DW'(RECOV_CYC - 1);
        end
      end
      ST_HOLD: begin
        if (dly_exp) st_d = ST_RD2;
      end
      ST_WR2: begin
        acc_en = 1'b1;
        if (acc_tmo || acc_ok) miss = 1'b1;
      end
      ST_GAP: begin
        if (dly_exp) st_d = ST_CHECK;
      end
      default: ;
    endcase

    if (miss) begin
      tries_d = tries_q + 1'b1;
      if (tries_q == CW'(MAX_TRIES - 1)) begin
        st_d   = ST_FAIL;
        fail_d = 1'b1;
      end else begin
        st_d     = ST_GAP;
        dly_load = 1'b1;
        dly_val  = DW'(GAP_CYC - 1);
      end
    end

    if (start) begin
      st_d     = ST_CHECK;
      tries_d  = '0;
      up_d     = 1'b0;
      fail_d   = 1'b0;
      evt_d    = 1'b0;
      dly_load = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tries_q <= '0;
      up_q    <= 1'b0;
      fail_q  <= 1'b0;
      evt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      tries_q <= tries_d;
      up_q    <= up_d;
      fail_q  <= fail_d;
      evt_q   <= evt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ov_q <= '0;
    else if (ov_en) ov_q <= ov_d;
  end

  // PHY request fields follow the state
  always_comb begin
    phy_we    = 1'b0;
    phy_addr  = '0;
    phy_wdata = '0;
    unique case (st_q)
      ST_RXV:         phy_addr = ADDR_RX_STAT;
      ST_RD1, ST_RD2: phy_addr = ADDR_RX_OVR;
      ST_WR1: begin
        phy_we    = 1'b1;
        phy_addr  = ADDR_RX_OVR;
        phy_wdata = ov_q | OVR_MASK;
      end
      ST_WR2: begin
        phy_we    = 1'b1;
        phy_addr  = ADDR_RX_OVR;
        phy_wdata = ov_q & ~OVR_MASK;
      end
      default: ;
    endcase
  end

  assign link_up   = up_q;
  assign link_fail = fail_q;
  assign stuck_evt = evt_q;

endmodule

// File: rtl/lum_link_monitor_chk.sv
module lum_link_monitor_chk #(
  parameter int PHY_TMO = 64
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        phy_req,
  input logic        phy_we,
  input logic [15:0] phy_addr,
  input logic [15:0] phy_wdata,
  input logic        phy_ack,
  input logic        link_up,
  input logic        link_fail,
  input logic        stuck_evt
);

  localparam int WW = $clog2(PHY_TMO + 2);

  logic [WW-1:0] wait_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 wait_cnt <= '0;
    else if (phy_req && !phy_ack) wait_cnt <= wait_cnt + 1'b1;
    else                        wait_cnt <= '0;
  end

  p_up_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && !start) |=> link_up);

  p_fail_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_fail && !start) |=> link_fail);

  p_verdict_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(link_up && link_fail));

  p_quiet_after_verdict_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up || link_fail) |-> !phy_req);

  p_evt_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stuck_evt |=> !stuck_evt);

  p_req_stable_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && !phy_ack && !start) |=>
      (!phy_req || ($stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata))));

  p_req_drop_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (phy_req && phy_ack) |=> !phy_req);

  p_req_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> (wait_cnt < WW'(PHY_TMO)));

  p_start_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!link_up && !link_fail));

endmodule

bind lum_link_monitor lum_link_monitor_chk #(.PHY_TMO(PHY_TMO)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .phy_req   (phy_req),
  .phy_we    (phy_we),
  .phy_addr  (phy_addr),
  .phy_wdata (phy_wdata),
  .phy_ack   (phy_ack),
  .link_up   (link_up),
  .link_fail (link_fail),
  .stuck_evt (stuck_evt)
);

// File: tb/lum_link_monitor_tb_top.sv
`timescale 1ns/1ps
module lum_link_monitor_tb_top;

  localparam int GAP   = 20;
  localparam int RECOV = 50;
  localparam int MAXT  = 6;
  localparam int TMO   = 8;
  localparam int LAT   = 2;
  localparam logic [15:0] OVR_INIT = 16'h1247;
  localparam logic [31:0] B_UP = 32'h0000_0010;
  localparam logic [31:0] B_TR = 32'h2000_0000;

  logic        clk = 1'b0;
  logic        rst_n, start;
  logic [31:0] dbg0, dbg1;
  logic        phy_req, phy_we, phy_ack;
  logic [15:0] phy_addr, phy_wdata, phy_rdata;
  logic        link_up, link_fail, stuck_evt;

  logic        ack_en;
  logic [15:0] rxv_val;
  logic [15:0] ovr_reg;
  int          lat;

  int n_chk = 0, n_fail = 0;
  int epoch = 0;

  always #10 clk = ~clk;

  lum_link_monitor #(.GAP_CYC(GAP), .RECOV_CYC(RECOV), .MAX_TRIES(MAXT), .PHY_TMO(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dbg_word0(dbg0), .dbg_word1(dbg1),
    .phy_req(phy_req), .phy_we(phy_we), .phy_addr(phy_addr), .phy_wdata(phy_wdata),
    .phy_ack(phy_ack), .phy_rdata(phy_rdata),
    .link_up(link_up), .link_fail(link_fail), .stuck_evt(stuck_evt)
  );

  // PHY access sequencer model
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_ack   <= 1'b0;
      phy_rdata <= '0;
      ovr_reg   <= OVR_INIT;
      lat       <= 0;
    end else begin
      phy_ack <= 1'b0;
      if (phy_req && !phy_ack && ack_en) begin
        if (lat == LAT) begin
          lat     <= 0;
          phy_ack <= 1'b1;
          if (phy_we) begin
            if (phy_addr == 16'h1005) ovr_reg <= phy_wdata;
          end else begin
            phy_rdata <= (phy_addr == 16'h100D) ? rxv_val :
                         (phy_addr == 16'h1005) ? ovr_reg : 16'hDEAD;
          end
        end else begin
          lat <= lat + 1;
        end
      end else if (!phy_req) begin
        lat <= 0;
      end
    end
  end

  // port monitor
  int cyc = 0, ep_seen = 0;
  logic req_d = 1'b0, ack_d = 1'b0, evt_d = 1'b0;
  int rxv_starts, last_rxv, min_gap, ovr_reads, set_ack_cyc, min_hold;
  int n_set, n_clr, cur_len, max_len, viol, evt_cnt, evt_wide, req_late;
  logic [15:0] set_data, clr_data;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (epoch != ep_seen) begin
      ep_seen = epoch;
      rxv_starts = 0; last_rxv = -1; min_gap = 1 << 30; ovr_reads = 0;
      set_ack_cyc = -1; min_hold = 1 << 30; n_set = 0; n_clr = 0;
      max_len = 0; viol = 0; evt_cnt = 0; evt_wide = 0; req_late = 0;
      set_data = '0; clr_data = '0;
    end
    if (phy_req && !req_d) begin
      if (phy_addr == 16'h100D && !phy_we) begin
        rxv_starts = rxv_starts + 1;
        if (last_rxv >= 0 && cyc - last_rxv < min_gap) min_gap = cyc - last_rxv;
        last_rxv = cyc;
      end
      if (phy_addr == 16'h1005 && !phy_we) begin
        ovr_reads = ovr_reads + 1;
        if (set_ack_cyc >= 0 && cyc - set_ack_cyc < min_hold) min_hold = cyc - set_ack_cyc;
        set_ack_cyc = -1;
      end
    end
    if (phy_req) begin
      cur_len = req_d ? cur_len + 1 : 1;
      if (cur_len > max_len) max_len = cur_len;
    end
    if (phy_req && phy_ack && phy_we) begin
      if ((phy_wdata & 16'h0028) == 16'h0028) begin
        n_set = n_set + 1; set_data = phy_wdata; set_ack_cyc = cyc;
      end else begin
        n_clr = n_clr + 1; clr_data = phy_wdata;
      end
    end
    if (req_d && ack_d && phy_req) viol = viol + 1;
    if (stuck_evt) begin
      evt_cnt = evt_cnt + 1;
      if (evt_d) evt_wide = evt_wide + 1;
    end
    if ((link_up || link_fail) && phy_req) req_late = req_late + 1;
    req_d = phy_req; ack_d = phy_ack; evt_d = stuck_evt;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk);
    start = 1'b1;
    epoch = epoch + 1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic t_reset();
    check(link_up == 0 && link_fail == 0, "R1 verdicts", {link_up, link_fail}, 0);
    check(stuck_evt == 0 && phy_req == 0, "R1 evt/req", {stuck_evt, phy_req}, 0);
  endtask

  task automatic t_up_direct();
    dbg1 = B_UP; dbg0 = '0;
    do_start();
    check(link_up == 0, "R2 not yet up after first edge", link_up, 0);
    @(negedge clk);
    check(link_up == 1, "R2 up on second edge", link_up, 1);
    dbg1 = '0;
    repeat (30) @(negedge clk);
    check(link_up == 1, "R2 sticky", link_up, 1);
    check(rxv_starts == 0, "R2 no PHY access", rxv_starts, 0);
  endtask

  task automatic t_training();
    dbg1 = B_UP | B_TR; dbg0 = 32'h0000_000D; rxv_val = 16'h0001;
    do_start();
    repeat (70) @(negedge clk);
    check(link_up == 0, "R3 in training not up", link_up, 0);
    check(rxv_starts >= 2, "R3 status reads", rxv_starts, 2);
    check(ovr_reads == 0 && evt_cnt == 0, "R4 no recovery when rx valid", ovr_reads + evt_cnt, 0);
    check(min_gap >= GAP, "R9 check spacing", min_gap, GAP);
    dbg1 = B_UP;
    for (int i = 0; i < 60 && !link_up; i++) @(negedge clk);
    check(link_up == 1, "R2 up after training ends", link_up, 1);
  endtask

  task automatic t_recover();
    dbg1 = '0; dbg0 = 32'h0000_000D; rxv_val = 16'h0000;
    do_start();
    for (int i = 0; i < 400 && n_clr == 0; i++) @(negedge clk);
    dbg1 = B_UP;
    check(evt_cnt >= 1, "R5 stuck pulse", evt_cnt, 1);
    check(evt_wide == 0, "R5 pulse width", evt_wide, 0);
    check(set_data == (OVR_INIT | 16'h0028), "R5 set write", set_data, OVR_INIT | 16'h0028);
    check(clr_data == OVR_INIT, "R6 clear write", clr_data, OVR_INIT);
    check(min_hold >= RECOV, "R6 hold time", min_hold, RECOV);
    for (int i = 0; i < 200 && !link_up; i++) @(negedge clk);
    check(link_up == 1, "R2 up after recovery", link_up, 1);
  endtask

  task automatic t_no_stuck();
    dbg1 = '0; dbg0 = 32'h0000_000C; rxv_val = 16'h0000;
    do_start();
    repeat (60) @(negedge clk);
    do_start();
    for (int i = 0; i < 600 && !link_fail; i++) @(negedge clk);
    check(link_fail == 1 && link_up == 0, "R8 fail verdict", {link_fail, link_up}, 2);
    check(rxv_starts == MAXT, "R11 restart clears count / R8 attempts", rxv_starts, MAXT);
    check(ovr_reads == 0, "R7 no recovery outside lock state", ovr_reads, 0);
    repeat (30) @(negedge clk);
    check(req_late == 0 && link_fail == 1, "R8 quiet and sticky", req_late, 0);
  endtask

  task automatic t_restart();
    dbg1 = B_UP;
    do_start();
    check(link_fail == 0, "R11 fail cleared", link_fail, 0);
    @(negedge clk);
    check(link_up == 1, "R11 new check runs", link_up, 1);
  endtask

  task automatic t_timeout();
    dbg1 = '0; dbg0 = '0; ack_en = 1'b0;
    do_start();
    for (int i = 0; i < 800 && !link_fail; i++) @(negedge clk);
    check(link_fail == 1, "R10 fail after timeouts", link_fail, 1);
    check(rxv_starts == MAXT, "R10 every timeout one attempt", rxv_starts, MAXT);
    check(max_len == TMO, "R10 request held PHY_TMO cycles", max_len, TMO);
    ack_en = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; dbg0 = '0; dbg1 = '0; ack_en = 1'b1; rxv_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_up_direct();
    t_training();
    check(viol == 0, "R12 request drop", viol, 0);
    t_recover();
    check(viol == 0, "R12 request drop", viol, 0);
    t_no_stuck();
    t_restart();
    t_timeout();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk + 1);
    $finish;
  end

endmodule